// File: doc/BRIEF.md
# Field-Swapping Soft Repair Wrapper for a Word-Organised SRAM

The block sits around a single-port SRAM of `ROWS` words, each `WIDTH` bits wide. It needs no spare rows or columns. Each word holds two bit fields of equal width. Faults in the high-sensitivity field do more harm to the system than faults in the low-sensitivity field. When a row has faults only in the sensitive field, the wrapper stores that row with the two fields exchanged. The damaged cells then hold the low-value bits, and the error correction further down the chain absorbs what is left.

A two-state controller picks what the wrapper does. In `ST_TEST` an external march-test engine drives the memory directly, with no exchange. For each mismatch it reports, the engine raises an error strobe together with the failing bit positions. The wrapper reduces that word separately over each field. If the high field shows a failure and the low field is clean, it marks the row group that holds the current address. One flag covers `ROWS_PER_FLAG` consecutive rows, so the fault map holds ceil(`ROWS`/`ROWS_PER_FLAG`) bits. In `ST_FUNC` every access looks up the flag of its row. For a marked row the two fields are exchanged through a single 2-to-1 select, before storage on a write and after readout on a read. A global `repair_en` input turns the exchange off so that repaired and unrepaired behaviour can be compared.

The controller has two transitions. `ST_FUNC` goes to `ST_TEST` when `test_mode` is sampled high, and this transition also clears the whole fault map. `ST_TEST` goes to `ST_FUNC` when `test_mode` is sampled low.

Top module: `soft_repair_wrap`

## Requirements
- R1: After reset the controller is in `ST_FUNC`, every flag is clear, and `mem_rdata` reads 0.
- R2: The transition from `ST_FUNC` to `ST_TEST` clears every row flag. Rows marked earlier are stored unswapped after that.
- R3: In `ST_TEST`, a cycle with `err_strobe` high is a marking event when the OR of `err_word` over the high field is 1 and the OR over the low field is 0. A marking event sets the flag numbered `mem_addr / ROWS_PER_FLAG`, which covers every row of that group.
- R4: An error word whose failures lie only in the low field, in both fields, or in neither field sets no flag. Only the bit positions in the word matter, not the stuck value.
- R5: `err_word` has no effect while `err_strobe` is low. `err_strobe` has no effect in `ST_FUNC`.
- R6: In `ST_FUNC` with `repair_en` high, data written to a flagged row reads back unchanged with `repair_en` high. In the array, the field bits are exchanged: the k-th lowest bit of the high field trades places with the k-th lowest bit of the low field. With the default masks the high field is bits {14,13,12,8,7,6,2} and the low field is bits {11,10,9,5,4,3,1}.
- R7: Rows whose flag is clear are stored and read with no exchange, whatever the value of `repair_en`.
- R8: With `repair_en` low, every access passes straight through, even to a flagged row.
- R9: Bits outside both fields (bit 0 with the default masks) keep their position at all times.
- R10: A read (`mem_en`=1, `mem_we`=0) presents its data on `mem_rdata` one clock later. `mem_rdata` holds that value until the next read, and writes and idle cycles do not change it.
- R11: Flags survive the return to `ST_FUNC` and stay in force until the next entry into `ST_TEST`.
- R12: In `ST_TEST` the memory is accessed with no exchange, even for flagged rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | Request for the test state |
| repair_en | input | 1 | Global enable for the field exchange |
| err_strobe | input | 1 | Mismatch reported by the march-test engine |
| err_word | input | WIDTH | Failing bit positions of the current row |
| mem_en | input | 1 | Access enable |
| mem_we | input | 1 | Write when 1, read when 0 |
| mem_addr | input | $clog2(ROWS) | Row address |
| mem_wdata | input | WIDTH | Write data |
| mem_rdata | output | WIDTH | Read data, one cycle after the read |

## Verification
The bench goes after the mixed-fault word: a design that used plain "high field has a fault" would mark rows that have failures in both fields. It checks an error word with failures only outside both fields, and a strobe that arrives in functional mode; a wrong design would mark rows in both cases. It reads every row back with the exchange turned off, which exposes a swap that pairs the wrong bits, moves bit 0, or divides the address by the wrong group size. Re-entering test mode must forget old flags, and a design that only set flags would keep exchanging. Test-mode accesses must bypass the exchange; a wrong design would store march data permuted.

// File: rtl/srw_pkg.sv
package srw_pkg;

    typedef enum logic {
        ST_FUNC = 1'b0,
        ST_TEST = 1'b1
    } srw_state_e;

    function automatic int bit_total(input logic [63:0] m);
        int c;
        c = 0;
        for (int i = 0; i < 64; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic int bits_below(input logic [63:0] m, input int b);
        int c;
        c = 0;
        for (int i = 0; i < 64; i++) if (i < b && m[i]) c++;
        return c;
    endfunction

    function automatic int nth_member(input logic [63:0] m, input int n);
        int c;
        int r;
        c = 0;
        r = -1;
        for (int i = 0; i < 64; i++) begin
            if (m[i]) begin
                if (c == n) r = i;
                c++;
            end
        end
        return r;
    endfunction

    // source bit for output bit b when the fields are exchanged
    function automatic int partner_of(input logic [63:0] hi, input logic [63:0] lo, input int b);
        int r;
        if (hi[b])      r = nth_member(lo, bits_below(hi, b));
        else if (lo[b]) r = nth_member(hi, bits_below(lo, b));
        else            r = b;
        return r;
    endfunction

endpackage

// File: rtl/srw_field_swap.sv
module srw_field_swap #(
    parameter int unsigned        W       = 15,
    parameter logic [W-1:0]       HI_MASK = '0,
    parameter logic [W-1:0]       LO_MASK = '0
) (
    input  logic [W-1:0] din,
    input  logic         sel,
    output logic [W-1:0] dout
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        localparam int SRC = srw_pkg::partner_of(64'(HI_MASK), 64'(LO_MASK), b);
        if (SRC == b) begin : g_keep
            assign dout[b] = din[b];
        end else begin : g_mux
            assign dout[b] = sel ? din[SRC] : din[b];
        end
    end
endmodule

// File: rtl/srw_flag_store.sv
module srw_flag_store #(
    parameter int unsigned NFLAGS = 16,
    parameter int unsigned FW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [FW-1:0]     idx,
    output logic              cur_flag,
    output logic [NFLAGS-1:0] flags
);
    logic [NFLAGS-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flags_q <= '0;
        else if (clr)    flags_q <= '0;
        else if (set_en) flags_q[idx] <= 1'b1;
    end

    assign cur_flag = flags_q[idx];
    assign flags    = flags_q;
endmodule

// File: rtl/srw_sram.sv
module srw_sram #(
    parameter int unsigned ROWS = 64,
    parameter int unsigned W    = 15,
    localparam int unsigned AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [ROWS];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en && we) cells[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (en && !we) rdata_q <= cells[addr];
    end

    assign rdata = rdata_q;

    // R10: output only moves on a read
    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && !we) |=> $stable(rdata));
endmodule

// File: rtl/soft_repair_wrap.sv
module soft_repair_wrap #(
    parameter int unsigned          ROWS          = 64,
    parameter int unsigned          WIDTH         = 15,
    parameter int unsigned          ROWS_PER_FLAG = 4,
    parameter logic [WIDTH-1:0]     HI_MASK       = 15'b111_000_111_000_100,
    parameter logic [WIDTH-1:0]     LO_MASK       = 15'b000_111_000_111_010,
    localparam int unsigned         AW            = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned         NFLAGS        = (ROWS + ROWS_PER_FLAG - 1) / ROWS_PER_FLAG,
    localparam int unsigned         FW            = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             repair_en,
    input  logic             err_strobe,
    input  logic [WIDTH-1:0] err_word,
    input  logic             mem_en,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_addr,
    input  logic [WIDTH-1:0] mem_wdata,
    output logic [WIDTH-1:0] mem_rdata
);
    import srw_pkg::*;

    initial begin
        assert (bit_total(64'(HI_MASK)) == bit_total(64'(LO_MASK)) && (HI_MASK & LO_MASK) == '0)
            else $error("field masks must be disjoint and of equal width");
    end

    srw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FUNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FUNC: if (test_mode)  state_d = ST_TEST;
            ST_TEST: if (!test_mode) state_d = ST_FUNC;
            default: state_d = ST_FUNC;
        endcase
    end

    logic          hi_any, lo_any;
    logic          clr_flags, mark_row, swap_now, cur_flag;
    logic [AW-1:0] group_full;
    logic [FW-1:0] fidx;
    logic [NFLAGS-1:0] flag_vec;

    assign hi_any     = |(err_word & HI_MASK);
    assign lo_any     = |(err_word & LO_MASK);
    assign group_full = mem_addr / AW'(ROWS_PER_FLAG);
    assign fidx       = FW'(group_full);

    always_comb begin
        clr_flags = 1'b0;
        mark_row  = 1'b0;
        swap_now  = 1'b0;
        unique case (state_q)
            ST_FUNC: begin
                clr_flags = test_mode;
                swap_now  = repair_en && cur_flag;
            end
            ST_TEST: begin
                mark_row  = err_strobe && hi_any && !lo_any;
            end
            default: ;
        endcase
    end

    srw_flag_store #(.NFLAGS(NFLAGS), .FW(FW)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(clr_flags), .set_en(mark_row),
        .idx(fidx), .cur_flag(cur_flag), .flags(flag_vec)
    );

    logic [WIDTH-1:0] wdata_arr, rdata_arr;
    logic             rd_swap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rd_swap_q <= 1'b0;
        else if (mem_en && !mem_we) rd_swap_q <= swap_now;
    end

    srw_field_swap #(.W(WIDTH), .HI_MASK(HI_MASK), .LO_MASK(LO_MASK)) u_wr_swap (
        .din(mem_wdata), .sel(swap_now), .dout(wdata_arr)
    );

    srw_sram #(.ROWS(ROWS), .W(WIDTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .en(mem_en), .we(mem_we), .addr(mem_addr),
        .wdata(wdata_arr), .rdata(rdata_arr)
    );

    srw_field_swap #(.W(WIDTH), .HI_MASK(HI_MASK), .LO_MASK(LO_MASK)) u_rd_swap (
        .din(rdata_arr), .sel(rd_swap_q), .dout(mem_rdata)
    );

    // R2: entering test wipes the fault map
    p_clear_on_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FUNC && test_mode) |=> (flag_vec == '0));
    // R5: functional mode never edits the map
    p_func_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FUNC && !test_mode) |=> $stable(flag_vec));
    // R4: a failure in the low field never marks
    p_low_fault_no_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEST && test_mode && err_strobe && lo_any) |=> $stable(flag_vec));
    // R3: a high-only failure marks the addressed group
    p_high_fault_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEST && test_mode && err_strobe && hi_any && !lo_any) |=> flag_vec[$past(fidx)]);
    // R12: no exchange is applied while testing
    p_test_no_swap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEST && mem_en && !mem_we) |=> !rd_swap_q);
endmodule

// File: tb/soft_repair_wrap_bench.sv
module soft_repair_wrap_bench;
    localparam int ROWS = 64, W = 15, RPF = 4, NF = 16;
    localparam logic [W-1:0] HI = 15'b111_000_111_000_100;
    localparam logic [W-1:0] LO = 15'b000_111_000_111_010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic test_mode = 0, repair_en = 0, err_strobe = 0, mem_en = 0, mem_we = 0;
    logic [W-1:0] err_word = '0, mem_wdata = '0, mem_rdata;
    logic [5:0] mem_addr = '0;

    int checks = 0, errors = 0;
    bit mflag [NF];
    bit in_test = 0;

    always #2.5 clk = ~clk;

    soft_repair_wrap u_soft_repair_wrap (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .repair_en(repair_en),
        .err_strobe(err_strobe), .err_word(err_word), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [W-1:0] exch(input logic [W-1:0] d);
        int hp [7];
        int lp [7];
        int nh, nl;
        logic [W-1:0] r;
        nh = 0; nl = 0; r = d;
        for (int i = 0; i < W; i++) begin
            if (HI[i]) begin hp[nh] = i; nh++; end
            if (LO[i]) begin lp[nl] = i; nl++; end
        end
        for (int k = 0; k < 7; k++) begin
            r[hp[k]] = d[lp[k]];
            r[lp[k]] = d[hp[k]];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [W-1:0] d, input logic ren);
        @(negedge clk);
        mem_en = 1; mem_we = 1; mem_addr = a; mem_wdata = d; repair_en = ren;
        @(negedge clk);
        mem_en = 0; mem_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic ren, output logic [W-1:0] d);
        @(negedge clk);
        mem_en = 1; mem_we = 0; mem_addr = a; repair_en = ren;
        @(negedge clk);
        mem_en = 0;
        d = mem_rdata;
    endtask

    task automatic strobe(input logic [5:0] a, input logic [W-1:0] w, input logic s);
        @(negedge clk);
        mem_addr = a; err_word = w; err_strobe = s;
        @(negedge clk);
        err_strobe = 0;
        if (in_test && s && |(w & HI) && !(|(w & LO))) mflag[a / RPF] = 1;
    endtask

    task automatic enter_test();
        @(negedge clk); test_mode = 1;
        @(negedge clk); in_test = 1;
        for (int i = 0; i < NF; i++) mflag[i] = 0;
    endtask

    task automatic leave_test();
        @(negedge clk); test_mode = 0;
        @(negedge clk); in_test = 0;
    endtask

    // store with repair on, read with repair off: exposes the stored layout
    task automatic probe_row(input logic [5:0] a, input string tag);
        logic [W-1:0] d, q;
        d = W'($urandom);
        wr(a, d, 1);
        rd(a, 1, q);
        check({tag, " R6 round trip"}, q, d);
        rd(a, 0, q);
        check({tag, " R7/R9 stored layout"}, q, mflag[a / RPF] ? exch(d) : d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] d, q;
        void'($urandom(32'd1234));
        for (int i = 0; i < NF; i++) mflag[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset rdata", mem_rdata, '0);
        probe_row(6'd9, "R1 no flag after reset");

        // R10: read latency and hold
        wr(6'd3, 15'h5a5a, 0);
        rd(6'd3, 0, q);
        check("R10 one-cycle read", q, 15'h5a5a);
        wr(6'd4, 15'h0f0f, 0);
        repeat (3) @(negedge clk);
        check("R10 hold across write/idle", mem_rdata, 15'h5a5a);

        // directed marking cases
        enter_test();
        strobe(6'd9,  15'h4000, 1);          // R3 high only -> group 2
        strobe(6'd21, 15'h0002, 1);          // R4 low only
        strobe(6'd29, 15'h4200, 1);          // R4 both fields
        strobe(6'd37, 15'h0040, 0);          // R5 strobe low
        strobe(6'd41, 15'h0001, 1);          // R4 outside both fields
        for (int k = 0; k < 6; k++) begin
            logic [5:0] a;
            logic [W-1:0] w;
            a = 6'($urandom_range(44, 63));
            w = W'($urandom);
            if (k % 2 == 0) w = w & HI;
            strobe(a, w, 1);
        end
        // R12: raw access in test mode even on a marked row
        wr(6'd10, 15'h1234, 1);
        rd(6'd10, 1, q);
        check("R12 test-mode read", q, 15'h1234);
        leave_test();
        rd(6'd10, 0, q);
        check("R12 test-mode write stored raw", q, 15'h1234);
        check("R3 model marks group 2", 15'(mflag[2]), 15'd1);

        // R5: strobe in functional mode does nothing
        strobe(6'd52, 15'h4000, 1);
        in_test = 0;

        // R6/R7/R9/R11 across every row
        for (int r = 0; r < ROWS; r++) probe_row(6'(r), "sweep");

        // R8: repair disabled passes straight through on a marked row
        d = W'($urandom);
        wr(6'd9, d, 0);
        rd(6'd9, 0, q);
        check("R8 pass-through", q, d);
        rd(6'd9, 1, q);
        check("R8 stored raw read repaired", q, exch(d));
        check("R9 bit0 kept", {14'd0, exch(15'h0001)[0]}, 15'd1);

        // R2: re-entry clears the map
        enter_test();
        leave_test();
        probe_row(6'd9, "R2 cleared group 2");
        probe_row(6'd11, "R2 cleared group 2 last row");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule